// File: doc/BRIEF.md
# Flash Page Program Buffer

This block is the data-collection and commit stage behind the page program commands of a serial flash device. It watches an already-sampled serial stream: one shift strobe per serial clock, with one or two data lines. From that stream it picks out a write-enable command or a program command, followed by a 24-bit start address. It then files each incoming data byte into a one-page staging buffer. The column pointer begins at the low address byte and wraps inside the page. A flag per column remembers which columns were filled.

When chip select is released, the block decides whether the command may commit. If it may, it merges the flagged bytes into a small on-chip array model. A cell can only lose ones, so each written cell takes the old value ANDed with the new one. The block then holds a busy indication for a programmable number of cycles. If any cell could not reach its requested value, an error flag is raised.

Top module: `page_prog_buf`

## Requirements
- R1: After reset every array byte reads FFh, and `busy`, `wel` and `progErr` are all 0.
- R2: A frame whose first eight bits are 06h sets `wel` on chip-select release. A program frame sent while `wel` is 0 writes nothing and never raises `busy`.
- R3: A program frame carries opcode 02h, then 24 address bits, then data bytes, all MSB first on `sio0`. Data byte k lands at column (addr[7:0]+k) of page addr[ADDR_W-1:8]; address bits at ADDR_W and above are ignored.
- R4: Columns past FFh wrap to column 00h of the same page.
- R5: When more than one page of bytes is sent, each column keeps the last byte that reached it, so only the final 256 bytes take effect.
- R6: Columns that received no byte in the frame keep their previous array value.
- R7: With opcode A2h the data phase moves two bits per shift, `sio1` carrying the higher bit (bit 7, then 5, 3, 1) and `sio0` the lower; one byte takes four shifts. Opcode and address still use `sio0` alone.
- R8: If chip select is released before the full address, before a whole data byte, or off a byte boundary, nothing is written, `busy` stays 0 and `wel` is cleared.
- R9: If `protMask` has the bit of the target sector (addr[ADDR_W-1:SECTOR_LSB]) set, nothing is written, `busy` stays 0 and `wel` is cleared.
- R10: On an accepted commit, `busy` rises in the cycle after chip-select release with `wel` already 0. It stays high for BUSY_BYTE cycles when exactly one byte was sent and for BUSY_PAGE cycles otherwise. Frames sent while `busy` is high have no effect.
- R11: A written cell becomes the old value AND the buffered byte. `progErr` is set by a commit in which any written cell differs from its requested byte, and cleared by a commit with no such cell.
- R12: The array content changes only at an accepted commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Chip select, active low, sampled on clk |
| shiftEn | input | 1 | One serial bit (or bit pair) is valid this cycle |
| sio0 | input | 1 | Serial data line; lower bit of a pair in dual mode |
| sio1 | input | 1 | Second data line; higher bit of a pair in dual mode |
| protMask | input | 2**(ADDR_W-SECTOR_LSB) | One protect bit per sector |
| rdAddr | input | ADDR_W | Array read address |
| rdData | output | 8 | Array byte at `rdAddr` |
| busy | output | 1 | Programming in progress |
| wel | output | 1 | Write-enable latch |
| progErr | output | 1 | Last commit left a cell different from its requested byte |

## Verification
The bench builds the block with a 1 KiB array, 512-byte sectors and busy periods of 40 and 6 cycles. This gives four pages in two sectors, which a reference model can compare exhaustively after every frame. Short busy periods make it possible to measure both busy lengths exactly. They also leave room to send a whole write-enable frame inside a busy window. The small sector size puts one protected and one open sector within a handful of frames. It also lets an address with set bits above the array width be aimed at page 0.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_PROG2 = 8'hA2;

  typedef struct packed {
    logic clrFrame;   // chip select idle: drop column flags
    logic addrShift;  // one address bit on sio0
    logic addrLast;   // final address bit: load column pointer
    logic dataShift;  // one data bit or bit pair
    logic dual;       // data moves two bits per shift
    logic byteDone;   // this shift completes a byte
    logic commit;     // merge flagged bytes into the array
  } dpStrobe_t;
endpackage

// File: rtl/pgbuf_ctrl.sv
module pgbuf_ctrl
  import pgbuf_pkg::*;
#(
  parameter int BUSY_PAGE = 2000,
  parameter int BUSY_BYTE = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selN,
  input  logic      shiftEn,
  input  logic      sio0,
  input  logic      protHit,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      wel
);
  localparam int CNT_W = $clog2(BUSY_PAGE + 1);

  logic             selQ;
  logic [7:0]       opc;
  logic [5:0]       bitCnt;
  logic [2:0]       bitInByte;
  logic [1:0]       byteCnt;
  logic [CNT_W-1:0] busyCnt;

  logic shiftOk, opcDone, isProg, isDual, inData, selRise, okProg;
  logic [3:0] step;

  always_comb begin
    shiftOk = shiftEn && !selN && !busy;
    opcDone = bitCnt >= 6'd8;
    isProg  = opcDone && (opc == OPC_PROG || opc == OPC_PROG2);
    isDual  = opc == OPC_PROG2;
    inData  = isProg && bitCnt == 6'd32;
    step    = isDual ? 4'd2 : 4'd1;
    selRise = selN && !selQ;
    okProg  = isProg && wel && bitCnt == 6'd32 && byteCnt != 2'd0 &&
              bitInByte == 3'd0 && !protHit;

    stb.clrFrame  = selN;
    stb.addrShift = shiftOk && opcDone && bitCnt < 6'd32;
    stb.addrLast  = shiftOk && bitCnt == 6'd31;
    stb.dataShift = shiftOk && inData;
    stb.dual      = isDual;
    stb.byteDone  = stb.dataShift && ({1'b0, bitInByte} + step == 4'd8);
    stb.commit    = selRise && !busy && okProg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= 1'b1;
      opc       <= '0;
      bitCnt    <= '0;
      bitInByte <= '0;
      byteCnt   <= '0;
    end else begin
      selQ <= selN;
      if (selN) begin
        bitCnt    <= '0;
        bitInByte <= '0;
        byteCnt   <= '0;
      end else if (shiftOk) begin
        if (bitCnt < 6'd32) bitCnt <= bitCnt + 6'd1;
        if (!opcDone) opc <= {opc[6:0], sio0};
        if (inData) bitInByte <= 3'(bitInByte + step);
        if (stb.byteDone && byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel     <= 1'b0;
      busy    <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (selRise && !busy) begin
        if (opcDone && opc == OPC_WREN) wel <= 1'b1;
        else if (isProg)                wel <= 1'b0;
      end
      if (stb.commit) begin
        busy    <= 1'b1;
        busyCnt <= (byteCnt == 2'd1) ? CNT_W'(BUSY_BYTE - 1) : CNT_W'(BUSY_PAGE - 1);
      end else if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else               busyCnt <= busyCnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pgbuf_dp.sv
module pgbuf_dp
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 8,
  parameter int SECTOR_LSB = 9
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    stb,
  input  logic                         sio0,
  input  logic                         sio1,
  input  logic [ADDR_W-1:0]            rdAddr,
  output logic [7:0]                   rdData,
  output logic [ADDR_W-SECTOR_LSB-1:0] tgtSector,
  output logic                         progErr
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PSEL_W     = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0]     adr;
  logic [PAGE_W-1:0]     col;
  logic [7:0]            dsr;
  logic [7:0]            nextByte;
  logic [7:0]            pbuf    [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] written;
  logic [7:0]            mem     [MEM_BYTES];
  logic [PSEL_W-1:0]     pageSel;
  logic                  anyMis;

  assign pageSel   = adr[ADDR_W-1:PAGE_W];
  assign tgtSector = adr[ADDR_W-1:SECTOR_LSB];
  assign rdData    = mem[rdAddr];
  assign nextByte  = stb.dual ? {dsr[5:0], sio1, sio0} : {dsr[6:0], sio0};

  always_comb begin
    anyMis = 1'b0;
    for (int c = 0; c < PAGE_BYTES; c++) begin
      if (written[c] && ((mem[{pageSel, PAGE_W'(c)}] & pbuf[c]) != pbuf[c]))
        anyMis = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adr     <= '0;
      col     <= '0;
      dsr     <= '0;
      written <= '0;
    end else if (stb.clrFrame) begin
      written <= '0;
    end else begin
      if (stb.addrShift) adr <= {adr[ADDR_W-2:0], sio0};
      if (stb.addrLast)  col <= {adr[PAGE_W-2:0], sio0};
      if (stb.dataShift) dsr <= nextByte;
      if (stb.byteDone) begin
        written[col] <= 1'b1;
        col          <= col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.byteDone) pbuf[col] <= nextByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      progErr <= 1'b0;
    end else if (stb.commit) begin
      for (int c = 0; c < PAGE_BYTES; c++) begin
        if (written[c])
          mem[{pageSel, PAGE_W'(c)}] <= mem[{pageSel, PAGE_W'(c)}] & pbuf[c];
      end
      progErr <= anyMis;
    end
  end
endmodule

// File: rtl/page_prog_buf.sv
module page_prog_buf
  import pgbuf_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int SECTOR_LSB = 9,
  parameter int BUSY_PAGE  = 2000,
  parameter int BUSY_BYTE  = 100
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                selN,
  input  logic                                shiftEn,
  input  logic                                sio0,
  input  logic                                sio1,
  input  logic [2**(ADDR_W-SECTOR_LSB)-1:0]   protMask,
  input  logic [ADDR_W-1:0]                   rdAddr,
  output logic [7:0]                          rdData,
  output logic                                busy,
  output logic                                wel,
  output logic                                progErr
);
  localparam int SECT_W = ADDR_W - SECTOR_LSB;

  dpStrobe_t         stb;
  logic [SECT_W-1:0] tgtSector;
  logic              protHit;

  assign protHit = protMask[tgtSector];

  pgbuf_ctrl #(.BUSY_PAGE(BUSY_PAGE), .BUSY_BYTE(BUSY_BYTE)) u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .shiftEn(shiftEn), .sio0(sio0),
    .protHit(protHit), .stb(stb), .busy(busy), .wel(wel)
  );

  pgbuf_dp #(.ADDR_W(ADDR_W), .PAGE_W(8), .SECTOR_LSB(SECTOR_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sio0(sio0), .sio1(sio1),
    .rdAddr(rdAddr), .rdData(rdData), .tgtSector(tgtSector), .progErr(progErr)
  );
endmodule

// File: rtl/page_prog_buf_chk.sv
module page_prog_buf_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              busy,
  input logic              wel,
  input logic              progErr
);
  AST_BUSY_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(selN)); // R10
  AST_WEL_LOW_AT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !wel); // R10
  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel)); // R2
  AST_CELL_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rdAddr) |-> ((rdData & ~$past(rdData)) == 8'h00)); // R11
  AST_ARRAY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdAddr) && !$stable(rdData)) |-> $rose(busy)); // R12
  AST_ERR_AT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(progErr) |-> $rose(busy)); // R11
endmodule

bind page_prog_buf page_prog_buf_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .selN(selN), .rdAddr(rdAddr), .rdData(rdData),
  .busy(busy), .wel(wel), .progErr(progErr)
);

// File: tb/page_prog_buf_bench.sv
module page_prog_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int SECTOR_LSB = 9;
  localparam int BUSY_PAGE = 40;
  localparam int BUSY_BYTE = 6;

  logic clk = 0, rstN = 0, selN = 1, shiftEn = 0, sio0 = 0, sio1 = 0;
  logic [1:0] protMask = 2'b00;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0] rdData;
  logic busy, wel, progErr;

  page_prog_buf #(.ADDR_W(ADDR_W), .SECTOR_LSB(SECTOR_LSB),
                  .BUSY_PAGE(BUSY_PAGE), .BUSY_BYTE(BUSY_BYTE)) u_page_prog_buf (
    .clk(clk), .rstN(rstN), .selN(selN), .shiftEn(shiftEn), .sio0(sio0), .sio1(sio1),
    .protMask(protMask), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .wel(wel), .progErr(progErr));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int a; logic [7:0] v; string req; } item_t;
  item_t q[$];
  int nChecks = 0, nErrors = 0;
  bit done = 0;
  logic [7:0] refMem [0:1023];
  logic [7:0] dBuf [0:299];
  logic expErr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: reads the array and compares with queued expectations
  initial begin
    rdAddr = '0;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rdAddr = ADDR_W'(it.a);
        #1;
        check(rdData === it.v, it.req, int'(rdData), int'(it.v));
      end
    end
  end

  task automatic expectPage(input int page, input string req);
    for (int c = 0; c < 256; c++) begin
      item_t it;
      it.a = page * 256 + c; it.v = refMem[page * 256 + c]; it.req = req;
      q.push_back(it);
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic modelProg(input logic [23:0] adr, input int n);
    logic [7:0] tb [0:255];
    bit fl [0:255];
    int page, st;
    bit mis;
    page = int'(adr[9:8]); st = int'(adr[7:0]); mis = 0;
    for (int c = 0; c < 256; c++) fl[c] = 0;
    for (int i = 0; i < n; i++) begin
      tb[(st + i) % 256] = dBuf[i];
      fl[(st + i) % 256] = 1;
    end
    for (int c = 0; c < 256; c++) if (fl[c]) begin
      if ((refMem[page*256+c] & tb[c]) != tb[c]) mis = 1;
      refMem[page*256+c] = refMem[page*256+c] & tb[c];
    end
    expErr = mis;
  endtask

  task automatic sh(input logic b1, input logic b0);
    @(negedge clk);
    shiftEn = 1; sio1 = b1; sio0 = b0;
  endtask

  task automatic frame(input logic [7:0] opc, input logic [23:0] adr, input int nAddr,
                       input int nBytes, input bit dual, input int extra);
    @(negedge clk);
    selN = 0; shiftEn = 0;
    for (int i = 7; i >= 0; i--) sh(0, opc[i]);
    for (int i = 0; i < nAddr; i++) sh(0, adr[23-i]);
    for (int b = 0; b < nBytes; b++) begin
      if (dual) for (int k = 0; k < 4; k++) sh(dBuf[b][7-2*k], dBuf[b][6-2*k]);
      else      for (int k = 7; k >= 0; k--) sh(0, dBuf[b][k]);
    end
    for (int i = 0; i < extra; i++) sh(1, 1);
    @(negedge clk);
    shiftEn = 0; selN = 1;
  endtask

  task automatic measureBusy(output int n);
    n = 0;
    for (int i = 0; i < BUSY_PAGE + 5; i++) begin
      @(negedge clk);
      if (busy) n++;
    end
  endtask

  task automatic writeEnable();
    frame(8'h06, 24'h0, 0, 0, 0, 0);
    @(negedge clk);
    check(wel === 1'b1, "R2 wel set by 06h", int'(wel), 1);
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 300; i++) dBuf[i] = 8'(i * 29 + seed);
  endtask

  // program with acceptance expected; checks busy length, wel, error and page
  task automatic goodProg(input logic [7:0] opc, input logic [23:0] adr, input int n,
                          input string req);
    int bc;
    writeEnable();
    frame(opc, adr, 24, n, opc == 8'hA2, 0);
    @(negedge clk);
    check(busy === 1'b1 && wel === 1'b0, {req, " R10 busy up, wel low"}, int'({busy, wel}), 2);
    measureBusy(bc);
    check(bc == ((n == 1) ? BUSY_BYTE : BUSY_PAGE) - 1, {req, " R10 busy length"}, bc,
          ((n == 1) ? BUSY_BYTE : BUSY_PAGE) - 1);
    modelProg(adr, n);
    check(progErr === expErr, {req, " R11 progErr"}, int'(progErr), int'(expErr));
    expectPage(int'(adr[9:8]), req);
  endtask

  // rejected program: no busy, wel cleared, page unchanged
  task automatic badProg(input logic [7:0] opc, input logic [23:0] adr, input int nAddr,
                         input int n, input int extra, input bit we, input string req);
    int bc;
    if (we) writeEnable();
    frame(opc, adr, nAddr, n, opc == 8'hA2, extra);
    measureBusy(bc);
    check(bc == 0, {req, " no busy"}, bc, 0);
    check(wel === 1'b0, {req, " wel cleared"}, int'(wel), 0);
    expectPage(int'(adr[9:8]), {req, " R12 page unchanged"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    int bc;
    for (int i = 0; i < 1024; i++) refMem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(busy === 0 && wel === 0 && progErr === 0, "R1 status after reset",
          int'({busy, wel, progErr}), 0);
    for (int p = 0; p < 4; p++) expectPage(p, "R1 array erased");

    // R2 program without write enable
    fill(8'h13);
    badProg(8'h02, 24'h000010, 24, 4, 0, 0, "R2 no wel");

    // R3 R6 R10 page program of four bytes
    goodProg(8'h02, 24'h000010, 4, "R3 R6 four bytes");
    // R10 single byte uses short busy
    fill(8'h5A);
    goodProg(8'h02, 24'h000105, 1, "R10 single byte");
    // R4 wrap, R3 high address bits ignored
    fill(8'h77);
    goodProg(8'h02, 24'hABC0FE, 3, "R4 R3 wrap at FEh");
    // R5 more than a page
    fill(8'h21);
    goodProg(8'h02, 24'h000210, 260, "R5 last 256 kept");
    // R7 dual-input with wrap
    fill(8'h9C);
    goodProg(8'hA2, 24'h0003F0, 20, "R7 dual input");

    // R8 aborts
    fill(8'h00);
    badProg(8'h02, 24'h000120, 16, 0, 0, 1, "R8 short address");
    badProg(8'h02, 24'h000120, 24, 0, 0, 1, "R8 no data");
    badProg(8'h02, 24'h000120, 24, 1, 3, 1, "R8 partial byte");
    badProg(8'hA2, 24'h000120, 24, 1, 1, 1, "R8 dual partial byte");

    // R9 protected sector
    protMask = 2'b10;
    badProg(8'h02, 24'h000300, 24, 2, 0, 1, "R9 protected sector");
    protMask = 2'b00;

    // R11 mismatch then clean commit
    for (int i = 0; i < 300; i++) dBuf[i] = 8'hFF;
    goodProg(8'h02, 24'h000010, 1, "R11 mismatch");
    check(progErr === 1'b1, "R11 error raised", int'(progErr), 1);
    for (int i = 0; i < 300; i++) dBuf[i] = 8'h00;
    goodProg(8'h02, 24'h000300, 1, "R11 clean");
    check(progErr === 1'b0, "R11 error cleared", int'(progErr), 0);

    // R10 write enable during busy is ignored
    fill(8'h44);
    writeEnable();
    frame(8'h02, 24'h000180, 24, 2, 0, 0);
    frame(8'h06, 24'h0, 0, 0, 0, 0);
    measureBusy(bc);
    check(wel === 1'b0, "R10 frame during busy ignored", int'(wel), 0);
    modelProg(24'h000180, 2);
    expectPage(1, "R10 page after busy");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule